// File: doc/BRIEF.md
# UART FIFO Trigger and Timeout Controller

This block holds the transmit and receive byte queues of one UART channel, 128 entries each, and turns their fill levels into three interrupt requests. The serial side pushes received bytes and pops bytes to transmit. The host side pops received bytes and pushes bytes to send. A control register write turns the queues on or off, clears them, and picks the trigger thresholds. The receive threshold and the transmit threshold are set on their own.

A second, extended register carries a gate bit. The transmit threshold can only be changed while that bit is set, and it comes up as a single slot after reset. A character-time tick drives a receive timeout. The timeout flags bytes that sit in a partly filled receive queue that the host has stopped reading. When the queues are disabled the channel acts as a one-byte holding register, and both thresholds become one.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: After reset: fifo_en is 0, both counts are 0, both overrun flags are 0, irq_rx_data and irq_rx_timeout are 0, irq_tx_space is 1, the receive threshold select is 0 (8 bytes) and the transmit threshold is 1.
- R2: On a control write, bit 0 sets fifo_en. With fifo_en at 1 each queue holds up to 128 bytes. With fifo_en at 0 each queue holds one byte, and both effective thresholds are 1.
- R3: Control bits 7:6 select the receive threshold: 00 gives 8, 01 gives 16, 10 gives 56 and 11 gives 60. irq_rx_data is 1 while rx_count is greater than or equal to the effective receive threshold.
- R4: Control bits 5:4 select the transmit threshold with the same encoding. The new value is taken only if bit 4 of the extended register was already 1 before the control write. Otherwise the transmit threshold keeps its value.
- R5: irq_tx_space is 1 while the number of free transmit slots (capacity minus tx_count) is greater than or equal to the effective transmit threshold.
- R6: A push into a full queue is dropped and sets that queue's sticky overrun flag.
- R7: A pop from an empty queue leaves the count and the data output unchanged.
- R8: A push and a pop in the same cycle both take effect when the queue is not empty, including when it is full. On an empty queue only the push takes effect.
- R9: Bytes leave each queue in the order they entered. The popped byte appears on the data output in the cycle after the pop strobe and is held until the next successful pop.
- R10: irq_rx_timeout rises one cycle after the 4th char_tick that arrives with the receive queue non-empty and no receive push or pop. It rises only if rx_count is below the effective receive threshold. A receive push or pop, or an empty queue, restarts the tick count.
- R11: Once raised, irq_rx_timeout stays 1 until a receive pop or a receive clear, even if more bytes arrive.
- R12: Control bit 1 clears the receive queue and bit 2 clears the transmit queue. A write that changes bit 0 clears both. A clear also zeroes the overrun flag of that queue and cancels any push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (enable, clears, threshold selects) |
| ext_we | input | 1 | Extended register write strobe |
| ext_wdata | input | 8 | Extended write data; bit 4 gates transmit threshold writes |
| tx_push | input | 1 | Host writes a byte to transmit |
| tx_din | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_dout | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 8 | Transmit queue occupancy |
| tx_overrun | output | 1 | Sticky: a transmit push was dropped |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a received byte |
| rx_dout | output | 8 | Last byte popped from the receive queue |
| rx_count | output | 8 | Receive queue occupancy |
| rx_overrun | output | 1 | Sticky: a receive push was dropped |
| char_tick | input | 1 | One pulse per character time |
| fifo_en | output | 1 | Queues enabled |
| irq_rx_data | output | 1 | Receive occupancy at or above threshold |
| irq_tx_space | output | 1 | Free transmit slots at or above threshold |
| irq_rx_timeout | output | 1 | Receive data stalled below threshold |

## Verification
The collision that matters is a push and a pop landing in the same cycle. The bench forces this at both ends of the receive queue. At full, it must not count as an overrun. At empty, the pop must be ignored while the push lands. It also forces a control-register clear in the same cycle as queue traffic. A behavioural queue model in the bench predicts every output on every cycle, and these cycles are judged against it along with explicit checks of count, data output and overrun.

// File: rtl/uft_pkg.sv
package uft_pkg;
   // control register bit positions
   localparam int unsigned CTL_EN_BIT    = 0;
   localparam int unsigned CTL_RXCLR_BIT = 1;
   localparam int unsigned CTL_TXCLR_BIT = 2;
   localparam int unsigned CTL_TXSEL_LO  = 4;
   localparam int unsigned CTL_RXSEL_LO  = 6;
   // extended register gate bit
   localparam int unsigned EXT_GATE_BIT  = 4;

   // threshold choices, in select order
   localparam int unsigned LVL_SEL0 = 8;
   localparam int unsigned LVL_SEL1 = 16;
   localparam int unsigned LVL_SEL2 = 56;
   localparam int unsigned LVL_SEL3 = 60;
   localparam int unsigned LVL_MAX  = LVL_SEL3;

   typedef logic [1:0] lvl_sel_t;

   function automatic int unsigned sel_to_level(input lvl_sel_t sel);
      case (sel)
         2'd0:    return LVL_SEL0;
         2'd1:    return LVL_SEL1;
         2'd2:    return LVL_SEL2;
         default: return LVL_SEL3;
      endcase
   endfunction
endpackage

// File: rtl/uft_fifo.sv
module uft_fifo #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned DW    = 8,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          single,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] count,
   output logic          overrun
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit          POW2 = ((1 << AW) == DEPTH);

   initial begin
      AST_FIFO_DEPTH_OK: assert (DEPTH >= 2 && DW >= 1) else $error("bad queue geometry");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic [CW-1:0] cap;
   logic          pop_ok, push_ok;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nx = wr_ptr + 1'b1;
         assign rd_nx = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign cap     = single ? CW'(1) : CW'(DEPTH);
   assign pop_ok  = pop && (count != '0);
   assign push_ok = push && ((count < cap) || pop_ok);

   always_ff @(posedge clk) begin
      if (!flush && push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         dout    <= '0;
         overrun <= 1'b0;
      end else if (flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_nx;
         if (pop_ok) begin
            rd_ptr <= rd_nx;
            dout   <= mem[rd_ptr];
         end
         if (push && !push_ok) overrun <= 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_COUNT_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R2
   AST_DROP_SETS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && count == cap && !flush) |=> overrun); // R6
   AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count == '0 && !flush) |=> $stable(dout)); // R7
   AST_FULL_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && count == cap && count != '0 && !flush) |=> (count == $past(count))); // R8
endmodule

// File: rtl/uft_cfg.sv
module uft_cfg
   import uft_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic [7:0]    ctl_wdata,
   input  logic          ext_we,
   input  logic [7:0]    ext_wdata,
   output logic          fifo_en,
   output logic [CW-1:0] rx_trig,
   output logic [CW-1:0] tx_trig,
   output logic          flush_rx,
   output logic          flush_tx
);
   logic          en_q, gate_q;
   lvl_sel_t      rx_sel_q;
   logic [CW-1:0] tx_lvl_q;
   logic          en_flip;

   assign en_flip  = ctl_we && (ctl_wdata[CTL_EN_BIT] != en_q);
   assign flush_rx = (ctl_we && ctl_wdata[CTL_RXCLR_BIT]) || en_flip;
   assign flush_tx = (ctl_we && ctl_wdata[CTL_TXCLR_BIT]) || en_flip;
   assign fifo_en  = en_q;
   assign rx_trig  = en_q ? CW'(sel_to_level(rx_sel_q)) : CW'(1);
   assign tx_trig  = en_q ? tx_lvl_q : CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         gate_q   <= 1'b0;
         rx_sel_q <= '0;
         tx_lvl_q <= CW'(1);
      end else begin
         if (ctl_we) begin
            en_q     <= ctl_wdata[CTL_EN_BIT];
            rx_sel_q <= ctl_wdata[CTL_RXSEL_LO +: 2];
            if (gate_q) tx_lvl_q <= CW'(sel_to_level(ctl_wdata[CTL_TXSEL_LO +: 2]));
         end
         if (ext_we) gate_q <= ext_wdata[EXT_GATE_BIT];
      end
   end

   AST_TX_LVL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !gate_q) |=> $stable(tx_lvl_q)); // R4
   AST_TX_LVL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lvl_q == CW'(1)) || (tx_lvl_q == CW'(LVL_SEL0)) || (tx_lvl_q == CW'(LVL_SEL1))
      || (tx_lvl_q == CW'(LVL_SEL2)) || (tx_lvl_q == CW'(LVL_SEL3))); // R4
endmodule

// File: rtl/uft_timeout.sv
module uft_timeout #(
   parameter int unsigned TO_CHARS = 4,
   parameter int unsigned CW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic          char_tick,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] trig,
   output logic          irq
);
   localparam int unsigned TW = $clog2(TO_CHARS + 1);

   initial begin
      AST_TO_CHARS_OK: assert (TO_CHARS >= 1) else $error("timeout length must be positive");
   end

   logic [TW-1:0] idle_q;
   logic          expired;

   assign expired = (idle_q == TW'(TO_CHARS)) && (count != '0) && (count < trig);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= '0;
         irq    <= 1'b0;
      end else if (flush) begin
         idle_q <= '0;
         irq    <= 1'b0;
      end else begin
         if (pop)          irq <= 1'b0;
         else if (expired) irq <= 1'b1;
         if (push || pop || count == '0)              idle_q <= '0;
         else if (char_tick && idle_q < TW'(TO_CHARS)) idle_q <= idle_q + 1'b1;
      end
   end

   AST_TO_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !irq); // R11
   AST_TO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(count) != '0 && $past(count) < $past(trig))); // R10
endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
module uart_fifo_trig_ctrl
   import uft_pkg::*;
#(
   parameter int unsigned DEPTH    = 128,
   parameter int unsigned DW       = 8,
   parameter int unsigned TO_CHARS = 4,
   localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic [7:0]    ctl_wdata,
   input  logic          ext_we,
   input  logic [7:0]    ext_wdata,
   input  logic          tx_push,
   input  logic [DW-1:0] tx_din,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_dout,
   output logic [CW-1:0] tx_count,
   output logic          tx_overrun,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_din,
   input  logic          rx_pop,
   output logic [DW-1:0] rx_dout,
   output logic [CW-1:0] rx_count,
   output logic          rx_overrun,
   input  logic          char_tick,
   output logic          fifo_en,
   output logic          irq_rx_data,
   output logic          irq_tx_space,
   output logic          irq_rx_timeout
);
   initial begin
      AST_DEPTH_HOLDS_LEVELS: assert (DEPTH >= LVL_MAX) else $error("queue shallower than top threshold");
   end

   logic [CW-1:0] rx_trig, tx_trig, cap, tx_free;
   logic          flush_rx, flush_tx;

   uft_cfg #(.CW(CW)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ext_we(ext_we), .ext_wdata(ext_wdata),
      .fifo_en(fifo_en), .rx_trig(rx_trig), .tx_trig(tx_trig),
      .flush_rx(flush_rx), .flush_tx(flush_tx)
   );

   uft_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush_rx), .single(!fifo_en),
      .push(rx_push), .din(rx_din), .pop(rx_pop),
      .dout(rx_dout), .count(rx_count), .overrun(rx_overrun)
   );

   uft_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush_tx), .single(!fifo_en),
      .push(tx_push), .din(tx_din), .pop(tx_pop),
      .dout(tx_dout), .count(tx_count), .overrun(tx_overrun)
   );

   uft_timeout #(.TO_CHARS(TO_CHARS), .CW(CW)) u_rxto (
      .clk(clk), .rst_n(rst_n), .flush(flush_rx),
      .push(rx_push), .pop(rx_pop), .char_tick(char_tick),
      .count(rx_count), .trig(rx_trig), .irq(irq_rx_timeout)
   );

   assign cap          = fifo_en ? CW'(DEPTH) : CW'(1);
   assign tx_free      = cap - tx_count;
   assign irq_rx_data  = (rx_count >= rx_trig);
   assign irq_tx_space = (tx_free >= tx_trig);

   AST_CLEAR_EMPTIES_RX: assert property (@(posedge clk) disable iff (!rst_n)
      flush_rx |=> (rx_count == '0 && !rx_overrun)); // R12
   AST_CLEAR_EMPTIES_TX: assert property (@(posedge clk) disable iff (!rst_n)
      flush_tx |=> (tx_count == '0 && !tx_overrun)); // R12
endmodule

// File: tb/sim_uart_fifo_trig_ctrl.sv
`timescale 1ns/1ps
module sim_uart_fifo_trig_ctrl;
   localparam int DEPTH = 128;

   logic       clk = 0, rst_n = 0;
   logic       ctl_we = 0, ext_we = 0;
   logic [7:0] ctl_wdata = 0, ext_wdata = 0;
   logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, char_tick = 0;
   logic [7:0] tx_din = 0, rx_din = 0;
   logic [7:0] tx_dout, rx_dout, tx_count, rx_count;
   logic       tx_overrun, rx_overrun, fifo_en, irq_rx_data, irq_tx_space, irq_rx_timeout;

   always #2.5 clk = ~clk;

   uart_fifo_trig_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ext_we(ext_we), .ext_wdata(ext_wdata),
      .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
      .tx_count(tx_count), .tx_overrun(tx_overrun),
      .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
      .rx_count(rx_count), .rx_overrun(rx_overrun), .char_tick(char_tick),
      .fifo_en(fifo_en), .irq_rx_data(irq_rx_data), .irq_tx_space(irq_tx_space),
      .irq_rx_timeout(irq_rx_timeout)
   );

   int checks = 0, errs = 0, cyc_n = 0;
   bit cmp_on = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int lv(input logic [1:0] s);
      case (s)
         2'd0: return 8;
         2'd1: return 16;
         2'd2: return 56;
         default: return 60;
      endcase
   endfunction

   // behavioural reference model
   logic [7:0] rxq[$], txq[$];
   bit   m_en, m_gate, m_rxo, m_txo, m_to;
   logic [1:0] m_rsel;
   int   m_txl, m_idle, m_cap, m_rxt, m_n0;
   logic [7:0] m_rxd, m_txd;
   bit   f_rx, f_tx, pk, qk;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_gate = 0; m_rsel = 0; m_txl = 1; rxq.delete(); txq.delete();
         m_rxd = 0; m_txd = 0; m_rxo = 0; m_txo = 0; m_idle = 0; m_to = 0;
      end else begin
         m_cap = m_en ? DEPTH : 1;
         m_rxt = m_en ? lv(m_rsel) : 1;
         m_n0  = rxq.size();
         f_rx = ctl_we && (ctl_wdata[1] || (ctl_wdata[0] != m_en));
         f_tx = ctl_we && (ctl_wdata[2] || (ctl_wdata[0] != m_en));
         if (f_rx) begin m_idle = 0; m_to = 0; end
         else begin
            if (rx_pop) m_to = 0;
            else if (m_idle == 4 && m_n0 > 0 && m_n0 < m_rxt) m_to = 1;
            if (rx_push || rx_pop || m_n0 == 0) m_idle = 0;
            else if (char_tick && m_idle < 4) m_idle++;
         end
         if (f_rx) begin rxq.delete(); m_rxo = 0; end
         else begin
            qk = rx_pop && rxq.size() > 0;
            pk = rx_push && (rxq.size() < m_cap || qk);
            if (rx_push && !pk) m_rxo = 1;
            if (qk) m_rxd = rxq.pop_front();
            if (pk) rxq.push_back(rx_din);
         end
         if (f_tx) begin txq.delete(); m_txo = 0; end
         else begin
            qk = tx_pop && txq.size() > 0;
            pk = tx_push && (txq.size() < m_cap || qk);
            if (tx_push && !pk) m_txo = 1;
            if (qk) m_txd = txq.pop_front();
            if (pk) txq.push_back(tx_din);
         end
         if (ctl_we) begin
            if (m_gate) m_txl = lv(ctl_wdata[5:4]);
            m_en = ctl_wdata[0];
            m_rsel = ctl_wdata[7:6];
         end
         if (ext_we) m_gate = ext_wdata[4];
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2 fifo_en", fifo_en, m_en);
         chk("R8 rx_count", rx_count, rxq.size());
         chk("R8 tx_count", tx_count, txq.size());
         chk("R9 rx_dout", rx_dout, m_rxd);
         chk("R9 tx_dout", tx_dout, m_txd);
         chk("R6 rx_overrun", rx_overrun, m_rxo);
         chk("R6 tx_overrun", tx_overrun, m_txo);
         chk("R3 irq_rx_data", irq_rx_data, int'(rxq.size() >= (m_en ? lv(m_rsel) : 1)));
         chk("R5 irq_tx_space", irq_tx_space,
             int'(((m_en ? DEPTH : 1) - txq.size()) >= (m_en ? m_txl : 1)));
         chk("R10 irq_rx_timeout", irq_rx_timeout, m_to);
      end
   end

   always @(posedge clk) begin
      cyc_n++;
      if (cyc_n > 150000) begin
         errs++;
         $display("FAIL R1 watchdog act=%0d exp=%0d", cyc_n, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

   task automatic nxt();
      @(negedge clk);
      ctl_we = 0; ext_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; char_tick = 0;
   endtask
   task automatic wr_ctl(input logic [7:0] d); nxt(); ctl_we = 1; ctl_wdata = d; endtask
   task automatic wr_ext(input logic [7:0] d); nxt(); ext_we = 1; ext_wdata = d; endtask
   task automatic rxpush(input logic [7:0] d); nxt(); rx_push = 1; rx_din = d; endtask
   task automatic txpush(input logic [7:0] d); nxt(); tx_push = 1; tx_din = d; endtask
   task automatic rxpop(); nxt(); rx_pop = 1; endtask
   task automatic txpop(); nxt(); tx_pop = 1; endtask
   task automatic tick(); nxt(); char_tick = 1; endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      nxt();
      cmp_on = 1;
      // R1 reset state
      chk("R1 fifo_en", fifo_en, 0);
      chk("R1 counts", rx_count + tx_count, 0);
      chk("R1 irq_tx_space", irq_tx_space, 1);
      chk("R1 irq_rx_data", irq_rx_data, 0);
      chk("R1 irq_rx_timeout", irq_rx_timeout, 0);

      // disabled: one-byte holding
      rxpush(8'h11); rxpush(8'h22); nxt();
      chk("R2 single-byte depth", rx_count, 1);
      chk("R6 overrun when holding full", rx_overrun, 1);
      chk("R2 rx threshold is 1 when disabled", irq_rx_data, 1);
      rxpop(); nxt();
      chk("R9 held byte", rx_dout, 8'h11);

      // enable: flips bit 0, clears both
      wr_ctl(8'h01); nxt();
      chk("R12 overrun cleared by enable change", rx_overrun, 0);

      // tx threshold write without gate
      wr_ctl(8'h31);
      for (int i = 0; i < 127; i++) txpush(i[7:0]);
      nxt();
      chk("R4 tx threshold held at 1 without gate", irq_tx_space, 1);
      wr_ext(8'h10); wr_ctl(8'h31); nxt();
      chk("R4 tx threshold 60 with gate", irq_tx_space, 0);
      for (int i = 0; i < 58; i++) txpop();
      nxt();
      chk("R5 59 free below 60", irq_tx_space, 0);
      txpop(); nxt();
      chk("R5 60 free meets 60", irq_tx_space, 1);
      chk("R9 tx order", tx_dout, 58);

      wr_ctl(8'h35); nxt();
      chk("R12 tx clear", tx_count, 0);

      // rx threshold 60
      wr_ctl(8'hC1);
      for (int i = 0; i < 59; i++) rxpush(i[7:0]);
      nxt();
      chk("R3 59 below 60", irq_rx_data, 0);
      rxpush(8'd59); nxt();
      chk("R3 60 reaches 60", irq_rx_data, 1);
      for (int i = 60; i < 128; i++) rxpush(i[7:0]);
      rxpush(8'hFF); nxt();
      chk("R6 full count", rx_count, 128);
      chk("R6 overrun on full push", rx_overrun, 1);
      nxt(); rx_push = 1; rx_din = 8'hEE; rx_pop = 1; nxt();
      chk("R8 swap at full keeps count", rx_count, 128);
      chk("R9 first byte out", rx_dout, 0);
      for (int i = 0; i < 128; i++) rxpop();
      nxt();
      chk("R9 last byte out", rx_dout, 8'hEE);
      rxpop(); nxt();
      chk("R7 empty pop holds data", rx_dout, 8'hEE);
      chk("R7 empty pop holds count", rx_count, 0);
      nxt(); rx_push = 1; rx_din = 8'h5A; rx_pop = 1; nxt();
      chk("R8 swap at empty keeps push", rx_count, 1);
      chk("R8 swap at empty ignores pop", rx_dout, 8'hEE);

      // timeout
      tick(); tick(); tick(); tick(); nxt();
      chk("R10 not yet", irq_rx_timeout, 0);
      nxt();
      chk("R10 fired", irq_rx_timeout, 1);
      rxpush(8'h11); nxt();
      chk("R11 stays across push", irq_rx_timeout, 1);
      rxpop(); nxt();
      chk("R11 cleared by read", irq_rx_timeout, 0);

      // at threshold: no timeout
      wr_ctl(8'h01);
      for (int i = 0; i < 7; i++) rxpush(i[7:0]);
      for (int i = 0; i < 6; i++) tick();
      nxt(); nxt();
      chk("R10 suppressed at threshold", irq_rx_timeout, 0);
      chk("R3 8 reaches 8", irq_rx_data, 1);

      // clear in same cycle as traffic
      nxt(); ctl_we = 1; ctl_wdata = 8'h03; rx_push = 1; rx_din = 8'h77; nxt();
      chk("R12 clear cancels push", rx_count, 0);
      wr_ctl(8'h00); nxt();
      chk("R12 disable clears", rx_count + tx_count, 0);
      wr_ctl(8'h01);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         nxt();
         rx_push = ($urandom_range(0, 2) != 0); rx_din = 8'($urandom);
         rx_pop  = ($urandom_range(0, 2) == 0);
         tx_push = ($urandom_range(0, 1) != 0); tx_din = 8'($urandom);
         tx_pop  = ($urandom_range(0, 1) != 0);
         char_tick = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 150) == 0) begin
            ctl_we = 1; ctl_wdata = 8'($urandom) | 8'h01;
            ctl_wdata[2:1] = 2'($urandom_range(0, 3) == 0 ? 3 : 0);
         end
         if ($urandom_range(0, 400) == 0) begin ctl_we = 1; ctl_wdata = 8'h00; end
         if ($urandom_range(0, 300) == 0) begin ext_we = 1; ext_wdata = 8'($urandom); end
         if ((i / 500) % 2 == 1) begin rx_pop = 0; rx_push = ($urandom_range(0, 9) == 0); end
      end
      nxt(); nxt();
      cmp_on = 0;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule